// File: doc/BRIEF.md
# Floppy Drive Control Latch

This block turns a single control byte from the processor into the interface lines for up to four floppy drives. The low bits of the byte are per-drive selects. They are active-low and may be cleared together. The block reduces them to a one-hot select vector, a binary drive index and a flag that says no drive is chosen. The side-select and motor-on bits of the same byte are routed only to the chosen drive. Every other drive has these lines held low. The top bit of the byte drives the double-density input of the disk controller on every control write.

A second, independent write strobe loads a printer data port. The port places the bitwise complement of the written byte on an 8-bit parallel output. Both ports share one write data bus. Every output is a register and keeps its value until the next write to its own port.

Top module: `fdl_ctrl_latch`

## Requirements
- R1: After synchronous reset, `drv_none` is 1, `drv_idx` is 0, and `drv_sel`, `drv_side`, `drv_motor`, `dense` and `prn_data` are all 0.
- R2: On a control write, byte bit i (i = 0..3) at 0 selects drive i. The next cycle shows `drv_sel` one-hot at bit i, `drv_idx` = i and `drv_none` = 0.
- R3: When several of bits 0..3 are 0 in one control write, the highest-numbered of those drives becomes the selected drive.
- R4: When bits 0..3 are all 1, the next cycle shows `drv_none` = 1, `drv_idx` = 0, and all of `drv_sel`, `drv_side` and `drv_motor` at 0.
- R5: Byte bit 4 is copied to `drv_side` of the selected drive. The side line of every other drive is 0.
- R6: Byte bit 6 is copied to `drv_motor` of the selected drive. The motor line of every other drive is 0.
- R7: Byte bit 7 is copied to `dense` on every control write, including writes that select no drive.
- R8: A printer write puts the bitwise complement of the written byte on `prn_data` in the next cycle.
- R9: In a cycle with neither write strobe high, all outputs keep their values, whatever is on `wdata`.
- R10: A printer write alone leaves every drive output and `dense` unchanged. A control write alone leaves `prn_data` unchanged. Byte bit 5 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control byte write strobe |
| prn_we | input | 1 | Printer data write strobe |
| wdata | input | 8 | Write data shared by both ports |
| drv_sel | output | NDRV | One-hot select of the chosen drive |
| drv_idx | output | 2 | Binary index of the chosen drive |
| drv_none | output | 1 | High when no drive is selected |
| drv_side | output | NDRV | Per-drive side select |
| drv_motor | output | NDRV | Per-drive motor-on |
| dense | output | 1 | Double-density input of the controller |
| prn_data | output | 8 | Inverted printer data |

## Verification
The hardest situation to reach is a byte with several select bits cleared at once while the side and motor bits are set. In that case a wrong priority sends side and motor to the wrong drive. The stimulus writes fixed bytes that clear two, three and all four selects with side and motor high. It then runs a long stretch of random control and printer writes. Some cycles raise both strobes at once, and idle cycles carry random data. A behavioural model in the bench predicts every output and is compared on each clock.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
    localparam int BYTE_W    = 8;
    localparam int MAX_DRV   = 4;
    localparam int SIDE_BIT  = 4;
    localparam int MOTOR_BIT = 6;
    localparam int DENS_BIT  = 7;

    typedef struct packed {
        logic side;
        logic motor;
        logic dens;
    } ctl_fields_t;

    function automatic ctl_fields_t split_ctl(input logic [BYTE_W-1:0] b);
        ctl_fields_t f;
        f.side  = b[SIDE_BIT];
        f.motor = b[MOTOR_BIT];
        f.dens  = b[DENS_BIT];
        return f;
    endfunction
endpackage

// File: rtl/fdl_sel_dec.sv
module fdl_sel_dec #(
    parameter int NDRV = 4,
    localparam int IDXW = (NDRV > 1) ? $clog2(NDRV) : 1
) (
    input  logic [NDRV-1:0] sel_n,
    output logic [NDRV-1:0] onehot,
    output logic [IDXW-1:0] idx,
    output logic            hit
);
    // clear_above[i] is high when no select at index i or above is active
    logic [NDRV:0] clear_above;
    assign clear_above[NDRV] = 1'b1;

    genvar g;
    generate
        for (g = NDRV - 1; g >= 0; g--) begin : g_prio
            assign clear_above[g] = clear_above[g+1] & sel_n[g];
            assign onehot[g]      = ~sel_n[g] & clear_above[g+1];
        end
    endgenerate

    assign hit = ~clear_above[0];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NDRV; i++) begin
            if (onehot[i]) idx = IDXW'(i);
        end
    end

    always_comb begin
        a_onehot_r3: assert ($onehot0(onehot) || $isunknown(sel_n));
    end
endmodule

// File: rtl/fdl_drv_regs.sv
module fdl_drv_regs #(
    parameter int NDRV = 4,
    localparam int IDXW = (NDRV > 1) ? $clog2(NDRV) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [NDRV-1:0]     onehot_nxt,
    input  logic [IDXW-1:0]     idx_nxt,
    input  logic                hit_nxt,
    input  fdl_pkg::ctl_fields_t fld,
    output logic [NDRV-1:0]     sel_q,
    output logic [IDXW-1:0]     idx_q,
    output logic                none_q,
    output logic [NDRV-1:0]     side_q,
    output logic [NDRV-1:0]     motor_q,
    output logic                dens_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            idx_q  <= '0;
            none_q <= 1'b1;
            dens_q <= 1'b0;
        end else if (we) begin
            sel_q  <= onehot_nxt;
            idx_q  <= idx_nxt;
            none_q <= ~hit_nxt;
            dens_q <= fld.dens;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NDRV; g++) begin : g_drv
            always_ff @(posedge clk) begin
                if (rst) begin
                    side_q[g]  <= 1'b0;
                    motor_q[g] <= 1'b0;
                end else if (we) begin
                    side_q[g]  <= onehot_nxt[g] & fld.side;
                    motor_q[g] <= onehot_nxt[g] & fld.motor;
                end
            end
        end
    endgenerate

    p_side_only_sel_r5: assert property (@(posedge clk) disable iff (rst)
        (side_q & ~sel_q) == '0);
    p_motor_only_sel_r6: assert property (@(posedge clk) disable iff (rst)
        (motor_q & ~sel_q) == '0);
    p_none_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        none_q |-> (sel_q == '0 && side_q == '0 && motor_q == '0));
    p_dens_follow_r7: assert property (@(posedge clk) disable iff (rst)
        we |=> dens_q == $past(fld.dens));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(sel_q) && $stable(side_q) && $stable(motor_q) && $stable(dens_q)));
endmodule

// File: rtl/fdl_prn_port.sv
module fdl_prn_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst)     dout <= '0;
        else if (we) dout <= ~din;
    end

    p_invert_r8: assert property (@(posedge clk) disable iff (rst)
        we |=> (dout ^ $past(din)) == '1);
    p_prn_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(dout));
endmodule

// File: rtl/fdl_ctrl_latch.sv
module fdl_ctrl_latch #(
    parameter int NDRV = 4,   // at most fdl_pkg::MAX_DRV
    localparam int IDXW = (NDRV > 1) ? $clog2(NDRV) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ctl_we,
    input  logic                        prn_we,
    input  logic [fdl_pkg::BYTE_W-1:0]  wdata,
    output logic [NDRV-1:0]             drv_sel,
    output logic [IDXW-1:0]             drv_idx,
    output logic                        drv_none,
    output logic [NDRV-1:0]             drv_side,
    output logic [NDRV-1:0]             drv_motor,
    output logic                        dense,
    output logic [fdl_pkg::BYTE_W-1:0]  prn_data
);
    import fdl_pkg::*;

    logic [NDRV-1:0] dec_onehot;
    logic [IDXW-1:0] dec_idx;
    logic            dec_hit;
    ctl_fields_t     fields;

    assign fields = split_ctl(wdata);

    fdl_sel_dec #(.NDRV(NDRV)) u_dec (
        .sel_n  (wdata[NDRV-1:0]),
        .onehot (dec_onehot),
        .idx    (dec_idx),
        .hit    (dec_hit)
    );

    fdl_drv_regs #(.NDRV(NDRV)) u_drv (
        .clk        (clk),
        .rst        (rst),
        .we         (ctl_we),
        .onehot_nxt (dec_onehot),
        .idx_nxt    (dec_idx),
        .hit_nxt    (dec_hit),
        .fld        (fields),
        .sel_q      (drv_sel),
        .idx_q      (drv_idx),
        .none_q     (drv_none),
        .side_q     (drv_side),
        .motor_q    (drv_motor),
        .dens_q     (dense)
    );

    fdl_prn_port #(.W(BYTE_W)) u_prn (
        .clk  (clk),
        .rst  (rst),
        .we   (prn_we),
        .din  (wdata),
        .dout (prn_data)
    );

    p_sel_consistent_r2: assert property (@(posedge clk) disable iff (rst)
        drv_none == (drv_sel == '0));
    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv_sel));
    p_sel_top_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && wdata[NDRV-1] == 1'b0) |=> drv_idx == IDXW'(NDRV - 1));
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (drv_none && drv_sel == '0 && drv_motor == '0 && prn_data == '0));
endmodule

// File: tb/fdl_ctrl_latch_test.sv
`timescale 1ns/1ps
module fdl_ctrl_latch_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic       prn_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [3:0] drv_sel, drv_side, drv_motor;
    logic [1:0] drv_idx;
    logic       drv_none, dense;
    logic [7:0] prn_data;

    always #2.5 clk = ~clk;

    fdl_ctrl_latch uut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .prn_we(prn_we), .wdata(wdata),
        .drv_sel(drv_sel), .drv_idx(drv_idx), .drv_none(drv_none),
        .drv_side(drv_side), .drv_motor(drv_motor), .dense(dense),
        .prn_data(prn_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int       m_idx;
    bit       m_none;
    bit [3:0] m_sel, m_side, m_mot;
    bit       m_dens;
    bit [7:0] m_prn;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_idx = 0; m_none = 1; m_sel = 0; m_side = 0; m_mot = 0; m_dens = 0; m_prn = 0;
    endtask

    task automatic model_ctl(input bit [7:0] d);
        m_none = 1; m_idx = 0; m_sel = 0; m_side = 0; m_mot = 0;
        for (int i = 0; i < 4; i++) if (d[i] == 1'b0) begin m_none = 0; m_idx = i; end
        if (!m_none) begin
            m_sel[m_idx]  = 1'b1;
            m_side[m_idx] = d[4];
            m_mot[m_idx]  = d[6];
        end
        m_dens = d[7];
    endtask

    task automatic compare_all();
        check("R2 drv_sel",   {28'd0, drv_sel},   {28'd0, m_sel});
        check("R2 drv_idx",   {30'd0, drv_idx},   m_idx);
        check("R4 drv_none",  {31'd0, drv_none},  {31'd0, m_none});
        check("R5 drv_side",  {28'd0, drv_side},  {28'd0, m_side});
        check("R6 drv_motor", {28'd0, drv_motor}, {28'd0, m_mot});
        check("R7 dense",     {31'd0, dense},     {31'd0, m_dens});
        check("R8 prn_data",  {24'd0, prn_data},  {24'd0, m_prn});
    endtask

    // called at a negative edge; returns at the next negative edge after comparing
    task automatic step(input bit c, input bit p, input bit [7:0] d);
        ctl_we = c; prn_we = p; wdata = d;
        @(posedge clk);
        #1;
        if (c) model_ctl(d);
        if (p) m_prn = ~d;
        @(negedge clk);
        ctl_we = 0; prn_we = 0;
        compare_all();
    endtask

    initial begin
        bit [3:0] s_sel, s_side, s_mot;
        bit       s_dens;
        bit [7:0] s_prn;
        model_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 none",  {31'd0, drv_none}, 32'd1);
        check("R1 sel",   {28'd0, drv_sel}, 32'd0);
        check("R1 side",  {28'd0, drv_side}, 32'd0);
        check("R1 motor", {28'd0, drv_motor}, 32'd0);
        check("R1 dense", {31'd0, dense}, 32'd0);
        check("R1 prn",   {24'd0, prn_data}, 32'd0);
        check("R1 idx",   {30'd0, drv_idx}, 32'd0);
        rst = 0;
        @(negedge clk);

        // R2 single selects, various side and motor values
        step(1, 0, 8'b0101_1110); check("R2 idx0", {30'd0, drv_idx}, 0);
        step(1, 0, 8'b1000_1101); check("R2 idx1", {30'd0, drv_idx}, 1);
        step(1, 0, 8'b0001_1011); check("R5 side drv2", {28'd0, drv_side}, 32'h4);
        step(1, 0, 8'b1100_0111); check("R6 motor drv3", {28'd0, drv_motor}, 32'h8);

        // R3 several selects at once
        step(1, 0, 8'b0101_0000); check("R3 all low -> 3", {30'd0, drv_idx}, 3);
        check("R3 motor on 3 only", {28'd0, drv_motor}, 32'h8);
        step(1, 0, 8'b0101_1010); check("R3 0,2 low -> 2", {30'd0, drv_idx}, 2);
        check("R3 side on 2 only", {28'd0, drv_side}, 32'h4);
        step(1, 0, 8'b0101_1100); check("R3 0,1 low -> 1", {30'd0, drv_idx}, 1);
        step(1, 0, 8'b0101_1000); check("R3 0,1,2 low -> 2", {30'd0, drv_idx}, 2);

        // R4 and R7: no drive, density still follows
        step(1, 0, 8'b1101_1111);
        check("R4 none", {31'd0, drv_none}, 1);
        check("R4 motor quiet", {28'd0, drv_motor}, 0);
        check("R7 dense on no-drive write", {31'd0, dense}, 1);
        step(1, 0, 8'b0101_1111); check("R7 dense cleared", {31'd0, dense}, 0);

        // R8 printer
        step(0, 1, 8'hA5); check("R8 invert A5", {24'd0, prn_data}, 32'h5A);

        // R10 printer write leaves drive state; control write leaves printer
        step(1, 0, 8'b1101_1101);
        s_sel = drv_sel; s_side = drv_side; s_mot = drv_motor; s_dens = dense;
        step(0, 1, 8'h00);
        check("R10 sel after prn write", {28'd0, drv_sel}, {28'd0, s_sel});
        check("R10 motor after prn write", {28'd0, drv_motor}, {28'd0, s_mot});
        check("R10 side after prn write", {28'd0, drv_side}, {28'd0, s_side});
        check("R10 dense after prn write", {31'd0, dense}, {31'd0, s_dens});
        s_prn = prn_data;
        step(1, 0, 8'h0E);
        check("R10 prn after ctl write", {24'd0, prn_data}, {24'd0, s_prn});
        // bit 5 has no effect
        step(1, 0, 8'b0101_0110); s_sel = drv_side | drv_motor;
        step(1, 0, 8'b0111_0110);
        check("R10 bit5 no effect", {28'd0, drv_side | drv_motor}, {28'd0, s_sel});

        // R9 idle cycles with random data
        s_sel = drv_sel; s_prn = prn_data;
        for (int k = 0; k < 5; k++) step(0, 0, 8'($urandom));
        check("R9 hold sel", {28'd0, drv_sel}, {28'd0, s_sel});
        check("R9 hold prn", {24'd0, prn_data}, {24'd0, s_prn});

        // random mix, including simultaneous strobes
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom_range(0, 3);
            step(r[0], r[1], 8'($urandom));
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule